// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block sits between a processor load port and a slower main memory. It holds recently loaded 32-bit words in four sets of two ways each. Every way keeps its own valid flag, 28-bit tag and data word and has its own tag comparator. Both ways of the addressed set are compared in the same cycle. Because of this, two addresses that share a set index can both stay resident, where a direct-mapped array would keep evicting one to make room for the other.

A load hits when either way of the selected set is valid and holds the matching tag. The word is then returned in the same cycle with no stall. On a miss the block raises a stall and sends a word-aligned request to memory. The request is held until memory answers with a valid pulse. The returned word goes to the processor in that cycle and is written into the victim way. The victim is an empty way if one exists, with way 0 chosen first. When the set is full, the victim is the way used least recently, tracked by one bit per set.

The processor holds its request and address steady while the stall is high. Stores are not supported.

Top module: `assoc2_cache`

## Requirements
- R1: Address bits 3:2 select one of four sets and bits 31:4 form the 28-bit tag. Bits 1:0 take no part in the lookup, so any byte offset of a resident word hits and returns the same word.
- R2: After reset no way is valid, so the first load to any address misses.
- R3: A load that misses raises ld_stall in its first cycle. From the next cycle on, mem_req is high with mem_addr equal to ld_addr with bits 1:0 cleared, and both stay unchanged until mem_valid is seen.
- R4: In the cycle mem_valid is high during a fetch, ld_done is high, ld_data equals mem_rdata, ld_stall is low, and the word is stored so that a later load of that address hits.
- R5: A load to a resident word gives ld_hit and ld_done in the same cycle, ld_data equal to the stored word, ld_stall low, and no memory request.
- R6: From an empty cache, alternating loads of 0x4 and 0x24 five times each give exactly 2 misses followed by 8 hits.
- R7: A fill goes to an invalid way when one exists (way 0 when both are invalid), so the second distinct tag in a set never evicts the first.
- R8: When both ways are valid, a miss replaces the way used least recently, where both hits and fills count as uses.
- R9: Loads and fills in one set never change which words are resident in another set.
- R10: No lookup ever reports a tag match in both ways of a set at once.
- R11: While ld_req is low and no fetch is in progress, ld_hit and ld_stall are low and no fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_req | input | 1 | Load request, held until ld_done |
| ld_addr | input | 32 | Byte address of the load |
| ld_data | output | 32 | Loaded word, valid while ld_done is high |
| ld_hit | output | 1 | Lookup matched a valid way this cycle |
| ld_done | output | 1 | Load completes this cycle (hit or fill) |
| ld_stall | output | 1 | Request pending and not complete |
| mem_req | output | 1 | Fetch request to main memory |
| mem_addr | output | 32 | Word-aligned fetch address |
| mem_valid | input | 1 | Memory returns the fetched word |
| mem_rdata | input | 32 | Word returned by memory |

## Verification
The bench goes after set conflicts: two tags alternating in one set must settle to all hits. A design with only one usable way per set would miss on every access instead. It also checks that a hit refreshes the replacement bit, using the order A, B, A, C in one set, after which B is gone and A stays. A design that updates the bit only on fills would evict A. Random loads over a few tags and offsets, with memory latencies from zero to three cycles, are checked against a reference model. Taken together they expose a wrong offset mask, a request that drops before the answer, or a fill written to the wrong way.

// File: rtl/c2w_pkg.sv
// Shared types and helpers for the two-way read cache.
// Assumes exactly two ways per set.
package c2w_pkg;

    // Miss controller states.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } c2w_state_e;

    // Victim choice: an empty way first (way 0 before way 1), else the LRU way.
    function automatic logic pick_victim(input logic v0, input logic v1, input logic lru_way);
        if (!v0)      return 1'b0;
        else if (!v1) return 1'b1;
        else          return lru_way;
    endfunction

endpackage

// File: rtl/c2w_way_store.sv
// One way of the cache: a valid flag, a tag and a data word per set, plus
// the tag comparator for that way. Reads are combinational on rd_set.
// Assumes at most one write per cycle. Only the valid flags are reset.
module c2w_way_store #(
    parameter int TAG_W    = 28,
    parameter int DATA_W   = 32,
    parameter int SET_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] rd_set,
    input  logic [TAG_W-1:0]    rd_tag,
    output logic                rd_valid,
    output logic                rd_hit,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [SET_BITS-1:0] wr_set,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [DATA_W-1:0]   wr_data
);
    localparam int NSETS = 1 << SET_BITS;

    logic [NSETS-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [NSETS];
    logic [DATA_W-1:0] data_q [NSETS];

    // Valid flags: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (wr_en) valid_q[wr_set] <= 1'b1;
    end

    // Tag and data storage written on a fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            data_q[wr_set] <= wr_data;
        end
    end

    // Lookup and tag compare for the addressed set.
    always_comb begin
        rd_valid = valid_q[rd_set];
        rd_hit   = rd_valid && (tag_q[rd_set] == rd_tag);
        rd_data  = data_q[rd_set];
    end

endmodule

// File: rtl/c2w_lru.sv
// Replacement state: one bit per set naming the way to replace next.
// A use of a way (hit or fill) points the bit at the other way.
// The victim is an empty way if one exists, else the way the bit names.
module c2w_lru #(
    parameter int SET_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] set_idx,
    input  logic                way0_valid,
    input  logic                way1_valid,
    input  logic                touch_en,
    input  logic                touch_way,
    output logic                victim
);
    import c2w_pkg::*;

    localparam int NSETS = 1 << SET_BITS;

    logic [NSETS-1:0] lru_q;

    // Update the LRU bit of the addressed set on each use.
    always_ff @(posedge clk) begin
        if (!rst_n)        lru_q <= '0;
        else if (touch_en) lru_q[set_idx] <= ~touch_way;
    end

    // Victim select for the addressed set.
    always_comb begin
        victim = pick_victim(way0_valid, way1_valid, lru_q[set_idx]);
    end

endmodule

// File: rtl/c2w_ctrl.sv
// Miss controller. A miss in idle starts a fetch: the word address is
// captured and mem_req is held until mem_valid. The fill happens in the
// mem_valid cycle. Assumes the processor holds ld_req/ld_addr while stalled.
module c2w_ctrl #(
    parameter int ADDR_W    = 32,
    parameter int OFFS_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              any_hit,
    input  logic              mem_valid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              hit_ev,
    output logic              fill_en
);
    import c2w_pkg::*;

    localparam logic [ADDR_W-1:0] OFFS_MASK = ADDR_W'((1 << OFFS_BITS) - 1);

    c2w_state_e        state_q;
    logic [ADDR_W-1:0] miss_addr_q;
    logic              start_fetch;

    // Decode the events of this cycle.
    always_comb begin
        hit_ev      = (state_q == ST_IDLE) && ld_req && any_hit;
        start_fetch = (state_q == ST_IDLE) && ld_req && !any_hit;
        fill_en     = (state_q == ST_FETCH) && mem_valid;
        mem_req     = (state_q == ST_FETCH);
        mem_addr    = miss_addr_q;
    end

    // State register: idle -> fetch on a miss, back on the memory answer.
    always_ff @(posedge clk) begin
        if (!rst_n)           state_q <= ST_IDLE;
        else if (start_fetch) state_q <= ST_FETCH;
        else if (fill_en)     state_q <= ST_IDLE;
    end

    // Capture the word-aligned miss address.
    always_ff @(posedge clk) begin
        if (!rst_n)           miss_addr_q <= '0;
        else if (start_fetch) miss_addr_q <= ld_addr & ~OFFS_MASK;
    end

endmodule

// File: rtl/assoc2_cache.sv
// Two-way set-associative read cache with one-word blocks.
// Two way stores are looked up in parallel. Way 1's match selects its
// data, otherwise way 0's. Misses go through the controller and fill
// the victim chosen by the replacement state.
// Assumes the load request and address stay stable while ld_stall is high.
module assoc2_cache #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SET_BITS  = 2,
    parameter int OFFS_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_hit,
    output logic              ld_done,
    output logic              ld_stall,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - SET_BITS - OFFS_BITS;
    localparam int NWAYS = 2;

    logic [SET_BITS-1:0] set_idx;
    logic [TAG_W-1:0]    tag;
    logic [NWAYS-1:0]    way_hit;
    logic [NWAYS-1:0]    way_valid;
    logic [DATA_W-1:0]   way_data [NWAYS];
    logic                victim;
    logic                hit_ev;
    logic                fill_en;
    logic [DATA_W-1:0]   sel_data;

    // Split the load address into set index and tag.
    always_comb begin
        set_idx = ld_addr[OFFS_BITS +: SET_BITS];
        tag     = ld_addr[ADDR_W-1 -: TAG_W];
    end

    // One storage array and comparator per way.
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        c2w_way_store #(
            .TAG_W    (TAG_W),
            .DATA_W   (DATA_W),
            .SET_BITS (SET_BITS)
        ) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_set   (set_idx),
            .rd_tag   (tag),
            .rd_valid (way_valid[w]),
            .rd_hit   (way_hit[w]),
            .rd_data  (way_data[w]),
            .wr_en    (fill_en && (victim == 1'(w))),
            .wr_set   (set_idx),
            .wr_tag   (tag),
            .wr_data  (mem_rdata)
        );
    end

    c2w_lru #(
        .SET_BITS (SET_BITS)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_idx    (set_idx),
        .way0_valid (way_valid[0]),
        .way1_valid (way_valid[1]),
        .touch_en   (hit_ev || fill_en),
        .touch_way  (fill_en ? victim : way_hit[1]),
        .victim     (victim)
    );

    c2w_ctrl #(
        .ADDR_W    (ADDR_W),
        .OFFS_BITS (OFFS_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_req    (ld_req),
        .ld_addr   (ld_addr),
        .any_hit   (|way_hit),
        .mem_valid (mem_valid),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .hit_ev    (hit_ev),
        .fill_en   (fill_en)
    );

    // Way multiplexer and processor-side outputs.
    always_comb begin
        sel_data = way_hit[1] ? way_data[1] : way_data[0];
        ld_hit   = hit_ev;
        ld_done  = hit_ev || fill_en;
        ld_data  = fill_en ? mem_rdata : sel_data;
        ld_stall = ld_req && !ld_done;
    end

endmodule

// File: rtl/c2w_checker.sv
// Protocol and structure checks for assoc2_cache, attached by bind.
module c2w_checker #(
    parameter int ADDR_W    = 32,
    parameter int OFFS_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_req,
    input logic              ld_hit,
    input logic              ld_done,
    input logic              ld_stall,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic [1:0]        way_hit
);
    // R10: the two comparators never match together.
    p_way_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R5: a hit completes at once with no fetch.
    p_hit_no_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> (!mem_req && !ld_stall && ld_done));

    // R3: a stalled load with no fetch yet starts one next cycle.
    p_miss_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_done && !mem_req) |=> mem_req);

    // R3: the request and its address hold until memory answers.
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R3: fetch addresses are word aligned.
    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFFS_BITS-1:0] == '0));

    // R4: the memory answer completes the load.
    p_fill_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |-> (ld_done && !ld_stall));

    // R11: no request and no fetch means no activity.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_req && !mem_req) |-> (!ld_hit && !ld_stall && !ld_done));

endmodule

bind assoc2_cache c2w_checker #(
    .ADDR_W    (ADDR_W),
    .OFFS_BITS (OFFS_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_req    (ld_req),
    .ld_hit    (ld_hit),
    .ld_done   (ld_done),
    .ld_stall  (ld_stall),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .way_hit   (way_hit)
);

// File: tb/assoc2_cache_tb.sv
module assoc2_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_req = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [31:0] ld_data;
    logic        ld_hit, ld_done, ld_stall, mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    bit          mv [4][2];
    logic [27:0] mt [4][2];
    bit          ml [4];

    always #4 clk = ~clk;

    assoc2_cache u_dut (
        .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_addr(ld_addr),
        .ld_data(ld_data), .ld_hit(ld_hit), .ld_done(ld_done), .ld_stall(ld_stall),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One load through the ports, checked against the model.
    task automatic do_load(input logic [31:0] a, input string rq, output bit hit_o);
        int s = int'(a[3:2]);
        logic [27:0] t = a[31:4];
        bit h0 = mv[s][0] && mt[s][0] == t;
        bit h1 = mv[s][1] && mt[s][1] == t;
        bit exp_hit = h0 || h1;
        int lat;
        bit vic;
        @(negedge clk);
        ld_req = 1'b1;
        ld_addr = a;
        #1;
        chk(ld_hit == exp_hit, rq, "ld_hit", 32'(ld_hit), 32'(exp_hit));
        hit_o = ld_hit;
        if (exp_hit) begin
            chk(ld_data == mem_word(a), rq, "hit data", ld_data, mem_word(a));
            chk(!ld_stall && !mem_req, rq, "hit stall/req", {ld_stall, mem_req}, 0);
            ml[s] = h1 ? 1'b0 : 1'b1;
            @(posedge clk);
        end else begin
            chk(ld_stall && !mem_req, rq, "miss stall", {ld_stall, mem_req}, 2);
            lat = $urandom_range(0, 3);
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                #1;
                chk(mem_req && ld_stall && mem_addr == {a[31:2], 2'b00}, "R3",
                    "request held", mem_addr, {a[31:2], 2'b00});
            end
            @(negedge clk);
            mem_valid = 1'b1;
            mem_rdata = mem_word(a);
            #1;
            chk(mem_req && mem_addr == {a[31:2], 2'b00}, "R3", "mem_addr",
                mem_addr, {a[31:2], 2'b00});
            chk(ld_done && !ld_stall && ld_data == mem_word(a), "R4", "fill data",
                ld_data, mem_word(a));
            vic = !mv[s][0] ? 1'b0 : (!mv[s][1] ? 1'b1 : ml[s]);
            mv[s][vic] = 1'b1;
            mt[s][vic] = t;
            ml[s] = ~vic;
            @(posedge clk);
        end
        #1;
        ld_req = 1'b0;
        mem_valid = 1'b0;
    endtask

    task automatic expect_hit(input logic [31:0] a, input bit want, input string rq);
        bit h;
        do_load(a, rq, h);
        chk(h == want, rq, "directed hit/miss", 32'(h), 32'(want));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit h;
        int hits;
        void'($urandom(32'h00C0_FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!ld_hit && !ld_stall && !mem_req, "R2", "reset outputs",
            {ld_hit, ld_stall, mem_req}, 0);

        // R2 + R6: conflict pattern in set 1.
        hits = 0;
        for (int i = 0; i < 5; i++) begin
            do_load(32'h4, "R6", h);
            hits += int'(h);
            do_load(32'h24, "R6", h);
            hits += int'(h);
        end
        chk(hits == 8, "R6", "hit count", 32'(hits), 8);

        // R1: byte offset does not matter.
        expect_hit(32'h7, 1'b1, "R1");
        expect_hit(32'h25, 1'b1, "R1");

        // R7: two tags fill empty ways of set 0 and both stay.
        expect_hit(32'h00, 1'b0, "R7");
        expect_hit(32'h10, 1'b0, "R7");
        expect_hit(32'h00, 1'b1, "R7");
        expect_hit(32'h10, 1'b1, "R7");

        // R8: A, B, A, C in set 2 evicts B, keeps A.
        expect_hit(32'h08, 1'b0, "R8");
        expect_hit(32'h18, 1'b0, "R8");
        expect_hit(32'h08, 1'b1, "R8");
        expect_hit(32'h28, 1'b0, "R8");
        expect_hit(32'h08, 1'b1, "R8");
        expect_hit(32'h18, 1'b0, "R8");

        // R9: activity in sets 0, 2, 3 left set 1 intact.
        expect_hit(32'h0C, 1'b0, "R9");
        expect_hit(32'h4, 1'b1, "R9");
        expect_hit(32'h24, 1'b1, "R9");

        // R11: idle port stays quiet.
        @(negedge clk);
        #1;
        chk(!ld_hit && !ld_stall && !ld_done, "R11", "idle outputs",
            {ld_hit, ld_stall, ld_done}, 0);
        @(negedge clk);
        #1;
        chk(!mem_req, "R11", "no fetch while idle", 32'(mem_req), 0);

        // Random loads over few tags: R5, R3, R4, R8, R10 against the model.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = {26'($urandom_range(0, 2)), 2'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
            a[31:30] = 2'($urandom_range(0, 1));
            do_load(a, "R5", h);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule